// File: doc/BRIEF.md
# Two-Level Carry-Lookahead Adder

A purely combinational 32-bit adder that forms every carry from lookahead equations rather than passing it bit to bit. The operand bits are split into eight 4-bit groups. Each group derives per-bit generate (AND of the operand bits) and propagate (OR of the operand bits). From these it produces its own internal carries as flat sum-of-products terms and a group-level generate/propagate pair.

A second lookahead level turns the eight group pairs into each group's carry-in. It works as two units of four groups, joined by a single two-term equation. Sum bits come from a separate XOR of the two operand bits and the bit's incoming carry.

The carry into bit 31 is exported next to the carry-out. A consumer can XOR the two to obtain signed overflow without a second adder.

Top module: `cla_adder32`

## Requirements
- R1: `sum` equals the low 32 bits of `a + b + cin`, with operands treated as unsigned.
- R2: `cout` equals bit 32 of `a + b + cin`.
- R3: `c_msb` equals the carry entering bit 31, which is bit 31 of `a[30:0] + b[30:0] + cin`.
- R4: `c_msb XOR cout` is 1 exactly when `a` and `b` share a sign bit and `sum[31]` differs from it (two's complement overflow).
- R5: With `a` all ones, `b` zero and `cin` 1, the carry crosses every group: `sum` is 0 and `cout` and `c_msb` are 1.
- R6: A carry generated at the top bit of any group (bit 4k+3) enters the next group: with only that bit set in both operands, `sum` has only bit 4k+4 set (or is 0 with `cout` = 1 when k = 7).
- R7: When no bit position has both operand bits set and every position has one of them set, the result passes `cin` through every group: `sum` is all ones for `cin` 0 and 0 for `cin` 1, and `cout` equals `cin`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a | input | 32 | First operand |
| b | input | 32 | Second operand |
| cin | input | 1 | Carry into bit 0 |
| sum | output | 32 | Sum bits |
| cout | output | 1 | Carry out of bit 31 |
| c_msb | output | 1 | Carry into bit 31 |

## Verification
The adder holds no registers, so every output is due in the same cycle in which the operands change, after combinational settling only. The bench drives a new operand set just after a rising clock edge and reads the outputs at the following falling edge, half a period later. No result is read across an edge where inputs move. Expected values come from a 33-bit behavioural addition in the bench and from a separate 31-bit addition for the carry into bit 31.

// File: rtl/cla_adder32.sv
module cla_adder32 (
  input  logic [31:0] a,
  input  logic [31:0] b,
  input  logic        cin,
  output logic [31:0] sum,
  output logic        cout,
  output logic        c_msb
);
  localparam int GW = 4;
  localparam int NG = 32 / GW;
  localparam int NS = NG / GW;

  function automatic logic [4:1] carries4(input logic [3:0] g, input logic [3:0] p, input logic c0);
    logic [4:1] c;
    c[1] = g[0] | (p[0] & c0);
    c[2] = g[1] | (p[1] & g[0]) | (p[1] & p[0] & c0);
    c[3] = g[2] | (p[2] & g[1]) | (p[2] & p[1] & g[0]) | (p[2] & p[1] & p[0] & c0);
    c[4] = g[3] | (p[3] & g[2]) | (p[3] & p[2] & g[1]) | (p[3] & p[2] & p[1] & g[0])
         | (p[3] & p[2] & p[1] & p[0] & c0);
    return c;
  endfunction

  function automatic logic group_gen(input logic [3:0] g, input logic [3:0] p);
    return g[3] | (g[2] & p[3]) | (g[1] & p[2] & p[3]) | (g[0] & p[1] & p[2] & p[3]);
  endfunction

  logic [31:0]   bg, bp, bc;
  logic [NG-1:0] grp_g, grp_p, grp_cin;
  logic [NS-1:0] sup_g, sup_p, sup_cin;

  assign bg = a & b;
  assign bp = a | b;

  genvar gi, si, bi;
  generate
    for (gi = 0; gi < NG; gi++) begin : g_grp
      assign grp_g[gi] = group_gen(bg[GW*gi +: GW], bp[GW*gi +: GW]);
      assign grp_p[gi] = &bp[GW*gi +: GW];
    end
    for (si = 0; si < NS; si++) begin : g_sup
      assign sup_g[si] = group_gen(grp_g[GW*si +: GW], grp_p[GW*si +: GW]);
      assign sup_p[si] = &grp_p[GW*si +: GW];
    end
  endgenerate

  assign sup_cin[0] = cin;
  assign sup_cin[1] = sup_g[0] | (sup_p[0] & cin);

  generate
    for (si = 0; si < NS; si++) begin : g_l2
      logic [4:1] sc;
      assign sc = carries4(grp_g[GW*si +: GW], grp_p[GW*si +: GW], sup_cin[si]);
      assign grp_cin[GW*si]   = sup_cin[si];
      assign grp_cin[GW*si+1] = sc[1];
      assign grp_cin[GW*si+2] = sc[2];
      assign grp_cin[GW*si+3] = sc[3];
    end
    for (gi = 0; gi < NG; gi++) begin : g_l1
      logic [4:1] gc;
      assign gc = carries4(bg[GW*gi +: GW], bp[GW*gi +: GW], grp_cin[gi]);
      assign bc[GW*gi] = grp_cin[gi];
      for (bi = 1; bi < GW; bi++) begin : g_bit
        assign bc[GW*gi+bi] = gc[bi];
      end
      if (gi == NG - 1) begin : g_top
        assign cout = gc[4];
      end
    end
  endgenerate

  assign sum   = a ^ b ^ bc;
  assign c_msb = bc[31];
endmodule

module cla_adder32_chk (
  input logic [31:0] a,
  input logic [31:0] b,
  input logic        cin,
  input logic [31:0] sum,
  input logic        cout,
  input logic        c_msb
);
  logic [32:0] ref_full;
  logic [31:0] ref_low;

  always_comb begin
    ref_full = {1'b0, a} + {1'b0, b} + {32'd0, cin};
    ref_low  = {1'b0, a[30:0]} + {1'b0, b[30:0]} + {31'd0, cin};
    a_r1_sum: assert ({cout, sum} == ref_full);
    a_r2_cout_majority: assert (cout == ((a[31] & b[31]) | ((a[31] | b[31]) & c_msb)));
    a_r3_msb_carry: assert (c_msb == ref_low[31]);
    a_r4_overflow: assert ((c_msb ^ cout) == ((a[31] == b[31]) && (sum[31] != a[31])));
    if (((a & b) == 32'd0) && ((a | b) == 32'hFFFF_FFFF))
      a_r7_pass_through: assert (cout == cin && sum == {32{~cin}});
  end
endmodule

bind cla_adder32 cla_adder32_chk u_chk (.*);

// File: tb/cla_adder32_tb.sv
module cla_adder32_tb;
  localparam time CLK_PERIOD = 10ns;

  logic clk = 1'b0;
  logic [31:0] a, b, sum;
  logic cin, cout, c_msb;
  int n_checks = 0;
  int n_fail = 0;
  bit done = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  cla_adder32 u_dut (.a(a), .b(b), .cin(cin), .sum(sum), .cout(cout), .c_msb(c_msb));

  task automatic expect_val(input string req, input logic [32:0] got, input logic [32:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h (a=%h b=%h cin=%0d)", req, got, exp, a, b, cin);
    end
  endtask

  task automatic apply_and_check(input logic [31:0] xa, input logic [31:0] xb, input logic xc);
    logic [32:0] full;
    logic [31:0] low;
    logic ovf;
    @(posedge clk);
    #1;
    a = xa; b = xb; cin = xc;
    @(negedge clk);
    full = {1'b0, xa} + {1'b0, xb} + {32'd0, xc};
    low  = {1'b0, xa[30:0]} + {1'b0, xb[30:0]} + {31'd0, xc};
    ovf  = (xa[31] == xb[31]) && (full[31] != xa[31]);
    expect_val("R1", {1'b0, sum}, {1'b0, full[31:0]});
    expect_val("R2", {32'd0, cout}, {32'd0, full[32]});
    expect_val("R3", {32'd0, c_msb}, {32'd0, low[31]});
    expect_val("R4", {32'd0, c_msb ^ cout}, {32'd0, ovf});
  endtask

  task automatic test_reset_zero;
    apply_and_check(32'd0, 32'd0, 1'b0);
    expect_val("R1 zero", {cout, sum}, 33'd0);
  endtask

  task automatic test_all_ones_plus_one;
    apply_and_check(32'hFFFF_FFFF, 32'd0, 1'b1);
    expect_val("R5", {c_msb, cout, sum}, {2'b11, 32'd0});
    apply_and_check(32'hFFFF_FFFF, 32'd1, 1'b0);
    expect_val("R5 b=1", {c_msb, cout, sum}, {2'b11, 32'd0});
  endtask

  task automatic test_group_boundaries;
    for (int k = 0; k < 8; k++) begin
      logic [31:0] v;
      logic [32:0] e;
      v = 32'd1 << (4 * k + 3);
      e = 33'd1 << (4 * k + 4);
      apply_and_check(v, v, 1'b0);
      expect_val("R6", {cout, sum}, e);
    end
  endtask

  task automatic test_pass_through;
    logic [31:0] pats [3] = '{32'hAAAA_AAAA, 32'h0F0F_0F0F, 32'h1234_5678};
    for (int i = 0; i < 3; i++) begin
      for (int c = 0; c < 2; c++) begin
        apply_and_check(pats[i], ~pats[i], c[0]);
        expect_val("R7", {cout, sum}, {c[0], {32{~c[0]}}});
      end
    end
  endtask

  task automatic test_overflow_edges;
    apply_and_check(32'h7FFF_FFFF, 32'd1, 1'b0);
    expect_val("R4 pos", {32'd0, c_msb ^ cout}, 33'd1);
    apply_and_check(32'h8000_0000, 32'h8000_0000, 1'b0);
    expect_val("R4 neg", {32'd0, c_msb ^ cout}, 33'd1);
    apply_and_check(32'h8000_0000, 32'h7FFF_FFFF, 1'b1);
    expect_val("R4 none", {32'd0, c_msb ^ cout}, 33'd0);
  endtask

  task automatic test_random;
    for (int i = 0; i < 300; i++)
      apply_and_check($urandom, $urandom, 1'($urandom));
  endtask

  initial begin
    a = '0; b = '0; cin = 1'b0;
    test_reset_zero();
    test_all_ones_plus_one();
    test_group_boundaries();
    test_pass_through();
    test_overflow_edges();
    test_random();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule